// File: doc/BRIEF.md
# Serial Receiver with Trigger-Level FIFO Status

This block is the receive half of an asynchronous serial port. A two-stage synchronizer brings the incoming line into the clock domain. A divider input sets the rate of a 16x oversampling enable. The receiver accepts a start bit only if the line is still low at the middle of that bit. It then samples 8 data bits, least significant first, at mid-bit. An optional even or odd parity bit and one stop bit follow. Each finished character goes into a 16-entry receive FIFO, together with its parity-error and framing-error bits.

Software uses four byte-wide registers, chosen by `reg_sel`. Select 0 is the data port, and each read of it pops one entry. Select 1 is the status register. Select 2 is the stored-byte count. Select 3 is the control register.

The status register has a receive-full flag (RDF) tied to a programmable trigger level. RDF clears only through a read-as-one-then-write-zero handshake. It also shows the error bits of the entry at the FIFO head. Sticky data-ready, error, break and overrun flags sit beside them, and writing 0 to a bit clears it.

Top module: `uart_rx_fifo_stat`

## Requirements
- R1: After reset, the status, count and control registers all read 0.
- R2: A character is received only while control bit 0 (enable) is 1. With it at 0, a complete frame on the line leaves the count unchanged.
- R3: Reading select 2 returns the number of stored bytes. The count goes up by one for each received character and down by one for each read of the data port.
- R4: Reading select 0 returns the oldest stored byte and removes it from the FIFO. Data bits are received least significant bit first.
- R5: Status bit 0 (RDF) becomes 1 when the count is at or above the trigger level. The trigger level is control bits [7:4] plus one.
- R6: Writing 0 to status bit 0 clears RDF only if a status read has returned bit 0 as 1 since the last clear. Without such a read, RDF stays 1.
- R7: If RDF is cleared while the count is still at or above the trigger level, RDF reads 1 again from the next cycle.
- R8: Status bit 3 (data ready) is set when the count is nonzero and below the trigger level, and the line has stayed idle for 240 oversampling ticks (15 bit periods) since the last character. Writing 0 to bit 3 clears it.
- R9: Control bit 1 enables a parity bit and control bit 2 selects odd parity (0 = even). Status bit 1 is the parity-error bit and status bit 2 the framing-error bit (stop bit sampled low) of the head entry. Both read 0 when the FIFO is empty.
- R10: Status bit 4 (error) is set by any character with a parity or framing error. Status bit 5 (break) is set when, after a framing error, the line stays low for 160 more oversampling ticks. Writing 0 to either bit clears it, and writing 1 leaves it unchanged.
- R11: A character that arrives while the FIFO holds 16 bytes is discarded, and sticky status bit 6 (overrun) is set.
- R12: A low pulse on the line that ends before the middle of the start bit produces no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial receive line, idle high |
| baud_div | input | 12 | Clocks per oversampling tick, minus one |
| reg_sel | input | 2 | Register select: 0 data, 1 status, 2 count, 3 control |
| reg_rd | input | 1 | Read strobe (pops the FIFO when select is 0) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |

## Verification
The bench targets the clear handshake first. It writes zero to RDF before RDF has been read, then clears RDF while the count still meets the trigger, then clears it once the count has dropped. A design that ignored the prior read would lose RDF early. A design without the re-raise would leave RDF low beside a full trigger. It sweeps bytes through both parity senses with correct and corrupted parity bits, checking the head error bits and the byte order. A wrong parity sense or bit order shows up as wrong data or spurious error bits. It also covers a stop bit followed by a short low and by a long low, to separate a plain framing error from a break. It fills the FIFO to 16 and sends a 17th character, which a design that wrapped its pointers would overwrite into the oldest entry. Finally it sends a short start glitch, which an edge-triggered receiver would take as a character.

// File: rtl/urx_pkg.sv
package urx_pkg;
   typedef struct packed {
      logic       fer;
      logic       per;
      logic [7:0] data;
   } urx_entry_t;

   localparam logic [1:0] SEL_DATA = 2'd0;
   localparam logic [1:0] SEL_STAT = 2'd1;
   localparam logic [1:0] SEL_CNT  = 2'd2;
   localparam logic [1:0] SEL_CTRL = 2'd3;

   localparam int B_RDF = 0;
   localparam int B_PER = 1;
   localparam int B_FER = 2;
   localparam int B_DR  = 3;
   localparam int B_ER  = 4;
   localparam int B_BRK = 5;
   localparam int B_OVR = 6;
endpackage

// File: rtl/urx_baud.sv
module urx_baud #(
   parameter int DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (cnt >= div) begin
         cnt  <= '0;
         tick <= 1'b1;
      end else begin
         cnt  <= cnt + 1'b1;
         tick <= 1'b0;
      end
   end
endmodule

// File: rtl/urx_frame.sv
module urx_frame #(
   parameter int BRK_TICKS  = 160,
   parameter bit HAS_PARITY = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               tick,
   input  logic               rx_i,
   input  logic               par_en,
   input  logic               par_odd,
   output logic               push,
   output urx_pkg::urx_entry_t entry,
   output logic               idle,
   output logic               brk_pulse
);
   localparam int BW = $clog2(BRK_TICKS + 1);

   typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRK} st_t;

   st_t         st;
   logic [1:0]  sync;
   logic [3:0]  ph;
   logic [2:0]  bitn;
   logic [7:0]  sh;
   logic        par_bad;
   logic [BW-1:0] bcnt;
   logic        use_par;
   logic        rxs;

   assign rxs  = sync[1];
   assign idle = (st == S_IDLE);

   generate
      if (HAS_PARITY) begin : g_par
         assign use_par = par_en;
      end else begin : g_nopar
         assign use_par = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync <= 2'b11;
      else        sync <= {sync[0], rx_i};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         ph        <= '0;
         bitn      <= '0;
         sh        <= '0;
         par_bad   <= 1'b0;
         bcnt      <= '0;
         push      <= 1'b0;
         entry     <= '0;
         brk_pulse <= 1'b0;
      end else begin
         push      <= 1'b0;
         brk_pulse <= 1'b0;
         if (!en) begin
            st <= S_IDLE;
            ph <= '0;
         end else if (tick) begin
            ph <= ph + 1'b1;
            unique case (st)
               S_IDLE: begin
                  ph <= '0;
                  if (!rxs) st <= S_START;
               end
               S_START: begin
                  if (ph == 4'd7) begin
                     ph   <= '0;
                     bitn <= '0;
                     st   <= rxs ? S_IDLE : S_DATA;
                  end
               end
               S_DATA: begin
                  if (ph == 4'd15) begin
                     sh      <= {rxs, sh[7:1]};
                     bitn    <= bitn + 1'b1;
                     par_bad <= 1'b0;
                     if (bitn == 3'd7) st <= use_par ? S_PAR : S_STOP;
                  end
               end
               S_PAR: begin
                  if (ph == 4'd15) begin
                     par_bad <= (rxs != (^sh ^ par_odd));
                     st      <= S_STOP;
                  end
               end
               S_STOP: begin
                  if (ph == 4'd15) begin
                     push      <= 1'b1;
                     entry.fer <= ~rxs;
                     entry.per <= par_bad & use_par;
                     entry.data <= sh;
                     bcnt      <= '0;
                     st        <= rxs ? S_IDLE : S_BRK;
                  end
               end
               S_BRK: begin
                  if (rxs) begin
                     st <= S_IDLE;
                  end else if (bcnt != BW'(BRK_TICKS)) begin
                     bcnt <= bcnt + 1'b1;
                     if (bcnt == BW'(BRK_TICKS - 1)) brk_pulse <= 1'b1;
                  end
               end
               default: st <= S_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/urx_fifo.sv
module urx_fifo #(
   parameter int DEPTH = 16,
   parameter int W     = 10,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count
);
   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic          do_push, do_pop;

   assign do_push = push && (count != CW'(DEPTH));
   assign do_pop  = pop && (count != '0);
   assign dout    = mem[rp];

   function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
      return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_push) wp <= nxt(wp);
         if (do_pop)  rp <= nxt(rp);
         if (do_push && !do_pop)      count <= count + 1'b1;
         else if (do_pop && !do_push) count <= count - 1'b1;
      end
   end
endmodule

// File: rtl/urx_status.sv
module urx_status #(
   parameter int DEPTH    = 16,
   parameter int IDLE_ETU = 15,
   localparam int CW      = $clog2(DEPTH + 1),
   localparam int IT      = IDLE_ETU * 16,
   localparam int TW      = $clog2(IT + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] count,
   input  logic [CW-1:0] trig,
   input  logic          push_evt,
   input  logic          err_evt,
   input  logic          brk_evt,
   input  logic          ovr_evt,
   input  logic          line_idle,
   input  logic          tick,
   input  logic          stat_rd,
   input  logic          stat_wr,
   input  logic [6:0]    wbits,
   output logic          rdf,
   output logic          dr,
   output logic          er,
   output logic          brk,
   output logic          ovr
);
   import urx_pkg::*;

   logic          rdf_seen, armed, fire;
   logic [TW-1:0] tcnt;

   assign fire = armed && line_idle && tick && (tcnt == TW'(IT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         tcnt  <= '0;
      end else if (push_evt) begin
         armed <= 1'b1;
         tcnt  <= '0;
      end else if (!line_idle) begin
         tcnt <= '0;
      end else if (armed && tick) begin
         tcnt <= tcnt + 1'b1;
         if (fire) armed <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdf      <= 1'b0;
         rdf_seen <= 1'b0;
      end else if (stat_wr && !wbits[B_RDF] && rdf_seen) begin
         rdf      <= 1'b0;
         rdf_seen <= 1'b0;
      end else begin
         if (count >= trig) rdf <= 1'b1;
         if (stat_rd && rdf) rdf_seen <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dr  <= 1'b0;
         er  <= 1'b0;
         brk <= 1'b0;
         ovr <= 1'b0;
      end else begin
         dr  <= (fire && count != '0 && count < trig) | (dr  & ~(stat_wr & ~wbits[B_DR]));
         er  <= err_evt | (er  & ~(stat_wr & ~wbits[B_ER]));
         brk <= brk_evt | (brk & ~(stat_wr & ~wbits[B_BRK]));
         ovr <= ovr_evt | (ovr & ~(stat_wr & ~wbits[B_OVR]));
      end
   end
endmodule

// File: rtl/uart_rx_fifo_stat.sv
module uart_rx_fifo_stat #(
   parameter int DEPTH      = 16,
   parameter int DIV_W      = 12,
   parameter int IDLE_ETU   = 15,
   parameter int BRK_TICKS  = 160,
   parameter bit HAS_PARITY = 1'b1,
   localparam int CW        = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_i,
   input  logic [DIV_W-1:0] baud_div,
   input  logic [1:0]       reg_sel,
   input  logic             reg_rd,
   input  logic             reg_wr,
   input  logic [7:0]       reg_wdata,
   output logic [7:0]       reg_rdata
);
   import urx_pkg::*;

   initial begin
      assert (DEPTH >= 2 && DEPTH <= 255) else $error("DEPTH out of range");
      assert (IDLE_ETU >= 1 && BRK_TICKS >= 2) else $error("timer limits out of range");
   end

   logic [7:0]   ctrl;
   logic         rx_en, tick, fr_push, push_g, fr_idle, brk_evt, pop;
   logic         stat_rd, stat_wr, full;
   urx_entry_t   fr_entry, head;
   logic [CW-1:0] fifo_count, trig;
   logic         st_rdf, st_dr, st_er, st_brk, st_ovr, head_per, head_fer;

   assign rx_en   = ctrl[0];
   assign push_g  = fr_push & rx_en;
   assign pop     = reg_rd && (reg_sel == SEL_DATA);
   assign stat_rd = reg_rd && (reg_sel == SEL_STAT);
   assign stat_wr = reg_wr && (reg_sel == SEL_STAT);
   assign full    = (fifo_count == CW'(DEPTH));

   always_comb begin
      int t;
      t = int'(ctrl[7:4]) + 1;
      if (t > DEPTH) t = DEPTH;
      trig = t[CW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              ctrl <= '0;
      else if (reg_wr && reg_sel == SEL_CTRL)  ctrl <= reg_wdata;
   end

   urx_baud #(.DIV_W(DIV_W)) baud_i (
      .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick)
   );

   urx_frame #(.BRK_TICKS(BRK_TICKS), .HAS_PARITY(HAS_PARITY)) frame_i (
      .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(tick), .rx_i(rx_i),
      .par_en(ctrl[1]), .par_odd(ctrl[2]), .push(fr_push), .entry(fr_entry),
      .idle(fr_idle), .brk_pulse(brk_evt)
   );

   urx_fifo #(.DEPTH(DEPTH), .W($bits(urx_entry_t))) fifo_i (
      .clk(clk), .rst_n(rst_n), .push(push_g), .din(fr_entry), .pop(pop),
      .dout(head), .count(fifo_count)
   );

   urx_status #(.DEPTH(DEPTH), .IDLE_ETU(IDLE_ETU)) status_i (
      .clk(clk), .rst_n(rst_n), .count(fifo_count), .trig(trig),
      .push_evt(push_g), .err_evt(push_g & (fr_entry.fer | fr_entry.per)),
      .brk_evt(brk_evt & rx_en), .ovr_evt(push_g & full), .line_idle(fr_idle),
      .tick(tick), .stat_rd(stat_rd), .stat_wr(stat_wr), .wbits(reg_wdata[6:0]),
      .rdf(st_rdf), .dr(st_dr), .er(st_er), .brk(st_brk), .ovr(st_ovr)
   );

   assign head_per = (fifo_count != '0) & head.per;
   assign head_fer = (fifo_count != '0) & head.fer;

   always_comb begin
      unique case (reg_sel)
         SEL_DATA: reg_rdata = (fifo_count != '0) ? head.data : 8'h00;
         SEL_STAT: reg_rdata = {1'b0, st_ovr, st_brk, st_er, st_dr, head_fer, head_per, st_rdf};
         SEL_CNT:  reg_rdata = 8'(fifo_count);
         default:  reg_rdata = ctrl;
      endcase
   end
endmodule

// File: rtl/urx_checker.sv
module urx_checker #(
   parameter int DEPTH = 16,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rx_en,
   input logic          pop,
   input logic          stat_wr,
   input logic          wd0,
   input logic [CW-1:0] count,
   input logic [CW-1:0] trig,
   input logic          rdf,
   input logic          ovr,
   input logic          head_per,
   input logic          head_fer
);
   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH)); // R3
   AST_OFF_NO_RX: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_en && !pop) |=> $stable(count)); // R2
   AST_RDF_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      (count >= trig && !(stat_wr && !wd0)) |=> rdf); // R5
   AST_RDF_FALL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rdf) |-> $past(stat_wr && !wd0)); // R6
   AST_OVR_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr) |-> ($past(count) == CW'(DEPTH))); // R11
   AST_HEAD_FLAGS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0) |-> (!head_per && !head_fer)); // R9
endmodule

bind uart_rx_fifo_stat urx_checker #(.DEPTH(DEPTH)) chk_i (
   .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .pop(pop), .stat_wr(stat_wr),
   .wd0(reg_wdata[0]), .count(fifo_count), .trig(trig), .rdf(st_rdf),
   .ovr(st_ovr), .head_per(head_per), .head_fer(head_fer)
);

// File: tb/uart_rx_fifo_stat_tb_top.sv
`timescale 1ns/1ps
module uart_rx_fifo_stat_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx = 1'b1;
   logic [11:0] baud_div = '0;
   logic [1:0]  reg_sel = '0;
   logic        reg_rd = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   int          checks = 0;
   int          fails = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   uart_rx_fifo_stat dut_i (
      .clk(clk), .rst_n(rst_n), .rx_i(rx), .baud_div(baud_div),
      .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] s, output logic [7:0] v);
      @(negedge clk);
      reg_sel = s; reg_rd = 1'b1;
      #1 v = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic wr(input logic [1:0] s, input logic [7:0] d);
      @(negedge clk);
      reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   // one bit = 16 clocks with baud_div = 0
   task automatic send(input logic [7:0] d, input bit pen, input bit podd,
                       input bit flip, input bit stopv, input int hold_low);
      @(negedge clk);
      rx = 1'b0; repeat (16) @(negedge clk);
      for (int i = 0; i < 8; i++) begin rx = d[i]; repeat (16) @(negedge clk); end
      if (pen) begin rx = (^d) ^ podd ^ flip; repeat (16) @(negedge clk); end
      rx = stopv; repeat (16) @(negedge clk);
      if (hold_low > 0) begin rx = 1'b0; repeat (hold_low) @(negedge clk); end
      rx = 1'b1; repeat (4) @(negedge clk);
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      logic [7:0] exp_b [4];
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      rd(2'd1, v); chk("R1 status", v, 8'h00);
      rd(2'd2, v); chk("R1 count", v, 8'h00);
      rd(2'd3, v); chk("R1 ctrl", v, 8'h00);

      send(8'h5A, 0, 0, 0, 1, 0);
      rd(2'd2, v); chk("R2 disabled count", v, 8'h00);

      // trigger 4, no parity
      wr(2'd3, 8'h31);
      rd(2'd3, v); chk("R1 ctrl readback", v, 8'h31);
      exp_b[0] = 8'hA5; exp_b[1] = 8'h3C; exp_b[2] = 8'h01; exp_b[3] = 8'hFF;
      for (int i = 0; i < 3; i++) begin
         send(exp_b[i], 0, 0, 0, 1, 0);
         rd(2'd2, v); chk("R3 count up", v, 8'(i + 1));
         rd(2'd1, v); chk("R5 below trigger", {7'd0, v[0]}, 8'h00);
      end
      repeat (260) @(negedge clk);
      rd(2'd1, v); chk("R8 data ready set", {7'd0, v[3]}, 8'h01);
      wr(2'd1, 8'hF7);
      rd(2'd1, v); chk("R8 data ready cleared", {7'd0, v[3]}, 8'h00);
      send(exp_b[3], 0, 0, 0, 1, 0);
      wr(2'd1, 8'hFE);
      rd(2'd1, v); chk("R6 clear without prior read", {7'd0, v[0]}, 8'h01);
      wr(2'd1, 8'hFE);
      rd(2'd1, v); chk("R7 re-raise at trigger", {7'd0, v[0]}, 8'h01);
      for (int i = 0; i < 4; i++) begin
         rd(2'd0, v); chk("R4 order", v, exp_b[i]);
         rd(2'd2, v); chk("R3 count down", v, 8'(3 - i));
      end
      rd(2'd1, v); chk("R5 flag held", {7'd0, v[0]}, 8'h01);
      wr(2'd1, 8'hFE);
      rd(2'd1, v); chk("R6 clear after read", {7'd0, v[0]}, 8'h00);

      // parity sweep: both senses, good and bad parity bits
      for (int m = 0; m < 2; m++) begin
         for (int b = 0; b < 2; b++) begin
            for (int k = 0; k < 4; k++) begin
               logic [7:0] d;
               d = 8'((k + 1) * 37 + m * 91 + b * 5);
               wr(2'd3, 8'hF3 | 8'(m << 2));
               send(d, 1, m[0], b[0], 1, 0);
               rd(2'd1, v);
               chk("R9 parity flag", {7'd0, v[1]}, 8'(b));
               chk("R9 framing flag clear", {7'd0, v[2]}, 8'h00);
               if (b == 1) chk("R10 error sticky", {7'd0, v[4]}, 8'h01);
               rd(2'd0, v); chk("R4 parity frame data", v, d);
               wr(2'd1, 8'hEF);
               rd(2'd1, v); chk("R10 error cleared", {7'd0, v[4]}, 8'h00);
            end
         end
      end

      // framing error without and with break
      wr(2'd3, 8'hF1);
      send(8'h42, 0, 0, 0, 0, 0);
      rd(2'd1, v);
      chk("R9 framing flag", {7'd0, v[2]}, 8'h01);
      chk("R10 error on framing", {7'd0, v[4]}, 8'h01);
      chk("R10 no break", {7'd0, v[5]}, 8'h00);
      rd(2'd0, v); chk("R4 framing data", v, 8'h42);
      wr(2'd1, 8'h00);
      send(8'h00, 0, 0, 0, 0, 200);
      rd(2'd1, v); chk("R10 break set", {7'd0, v[5]}, 8'h01);
      wr(2'd1, 8'hFF);
      rd(2'd1, v); chk("R10 write one keeps break", {7'd0, v[5]}, 8'h01);
      rd(2'd0, v);
      wr(2'd1, 8'hDF);
      rd(2'd1, v); chk("R10 break cleared", {7'd0, v[5]}, 8'h00);
      send(8'h81, 0, 0, 0, 1, 0);
      rd(2'd1, v); chk("R9 clean frame after break", {7'd0, v[2]}, 8'h00);
      rd(2'd0, v); chk("R4 after break", v, 8'h81);
      wr(2'd1, 8'h00);

      // overrun
      for (int i = 0; i < 17; i++) begin
         send(8'(i * 13 + 7), 0, 0, 0, 1, 0);
         if (i == 15) begin
            rd(2'd1, v); chk("R11 no overrun at full", {7'd0, v[6]}, 8'h00);
         end
      end
      rd(2'd2, v); chk("R11 count capped", v, 8'd16);
      rd(2'd1, v); chk("R11 overrun set", {7'd0, v[6]}, 8'h01);
      for (int i = 0; i < 16; i++) begin
         rd(2'd0, v); chk("R11 kept bytes", v, 8'(i * 13 + 7));
      end
      rd(2'd2, v); chk("R11 dropped byte absent", v, 8'h00);
      wr(2'd1, 8'hBF);
      rd(2'd1, v); chk("R11 overrun cleared", {7'd0, v[6]}, 8'h00);

      // start glitch
      @(negedge clk); rx = 1'b0;
      repeat (5) @(negedge clk); rx = 1'b1;
      repeat (300) @(negedge clk);
      rd(2'd2, v); chk("R12 glitch ignored", v, 8'h00);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule